// File: doc/BRIEF.md
# Block Transfer Engine with Shared-Bus Policies

This single-channel engine copies a block of words across the system bus so the processor does not have to move each word itself. Software supplies a source address, a destination address, a word count, a transfer direction and a bus-sharing mode, then pulses a start input. The engine gains the bus through a request/grant handshake with the processor. It moves one word per bus beat, or two beats per word when copying memory to memory. When the count runs out it raises a sticky done flag and pulses an interrupt.

Two bus-sharing policies exist. The stealing policy hands the bus back after every word and stays off the bus for at least one cycle before it asks again. The transparent policy keeps its request raised and moves data only in cycles that the processor marks idle. Device transfers are paced by the device's request line, and each word the engine moves is answered with an acknowledge strobe.

Top module: `dma_engine`

## Requirements
- R1: A start pulse while the engine is idle latches source, destination, count, direction and mode; with a nonzero count, busy_o and bus_req_o are high from the next cycle until the last word has moved.
- R2: Direction code 2'b00 moves device data to memory at the destination address, 2'b01 moves memory data from the source address to the device, and 2'b10 or 2'b11 copies memory to memory.
- R3: mem_rd_o, mem_wr_o and dev_ack_o are only ever high in a cycle where bus_req_o and bus_gnt_i are both high, and mem_rd_o and mem_wr_o are never high together.
- R4: A memory-to-memory word takes a read beat at the source address, which captures mem_rdata_i, and then a write beat at the destination address that drives the captured value; both addresses then step up by one.
- R5: In stealing mode (cfg_mode_i = 0), bus_req_o is low for at least the cycle after every word that is not the last.
- R6: In transparent mode (cfg_mode_i = 1), a beat happens only in a cycle with cpu_idle_i high, and bus_req_o stays high between words.
- R7: A device word moves only in a cycle with dev_req_i high; that cycle carries dev_ack_o; mem_wdata_o equals dev_rdata_i for device-to-memory writes, and dev_wdata_o equals mem_rdata_i for memory-to-device reads.
- R8: After the last word, busy_o and bus_req_o drop on the next cycle, done_o goes high and stays high, and irq_o is high for exactly that one cycle.
- R9: A start pulse while busy_o is high is ignored: the running transfer keeps its count, addresses and direction.
- R10: A start with a count of zero raises done_o and a one-cycle irq_o on the next cycle without ever raising bus_req_o.
- R11: Addresses are 24 bits wide and wrap from 24'hFFFFFF to 24'h000000.
- R12: done_o is cleared by the next accepted start with a nonzero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_start_i | input | 1 | One-cycle start pulse |
| cfg_src_i | input | 24 | Source word address |
| cfg_dst_i | input | 24 | Destination word address |
| cfg_count_i | input | 16 | Number of words |
| cfg_dir_i | input | 2 | Direction code |
| cfg_mode_i | input | 1 | 0 stealing, 1 transparent |
| bus_req_o | output | 1 | Bus request to processor |
| bus_gnt_i | input | 1 | Bus grant from processor |
| cpu_idle_i | input | 1 | Processor leaves bus unused this cycle |
| mem_addr_o | output | 24 | Memory word address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, same cycle |
| dev_req_i | input | 1 | Device ready for a word |
| dev_ack_o | output | 1 | Word moved for device |
| dev_rdata_i | input | 16 | Data from device |
| dev_wdata_o | output | 16 | Data to device |
| busy_o | output | 1 | Transfer running |
| done_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
The checks assume the processor raises bus_gnt_i only while bus_req_o is high. They also assume memory returns read data in the same cycle as the strobe. The bench's grant model follows this rule: it drives grant from the registered request sampled mid-cycle, combined with a random enable, and it answers reads from a pure function of the address. The idle and device-request lines are random each cycle. Start pulses come at any time, including during a transfer, because ignoring a start while busy is part of the behaviour under test.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {DIR_D2M = 2'b00, DIR_M2D = 2'b01, DIR_M2M = 2'b10, DIR_M2M_ALT = 2'b11} dir_e;
  typedef enum logic {MODE_STEAL = 1'b0, MODE_TRANSP = 1'b1} mode_e;
  typedef enum logic [1:0] {S_IDLE, S_BUS, S_GAP} st_e;

  function automatic logic is_m2m(dir_e d);
    return d[1];
  endfunction
endpackage

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  zero_i,
  input  logic  last_i,
  input  dir_e  dir_i,
  input  mode_e mode_i,
  input  logic  gnt_i,
  input  logic  idle_i,
  input  logic  dev_req_i,
  output logic  bus_req_o,
  output logic  beat_o,
  output logic  phase_o,
  output logic  word_done_o,
  output logic  finish_o,
  output logic  load_o,
  output logic  busy_o
);
  st_e  st_q, st_d;
  logic ph_q, ph_d;

  assign load_o      = (st_q == S_IDLE) && start_i;
  assign bus_req_o   = (st_q == S_BUS);
  assign busy_o      = (st_q != S_IDLE);
  assign phase_o     = ph_q;
  assign beat_o      = bus_req_o && gnt_i && (mode_i == MODE_STEAL || idle_i)
                       && (is_m2m(dir_i) || dev_req_i);
  // m2m read beat does not finish the word
  assign word_done_o = beat_o && !(is_m2m(dir_i) && !ph_q);
  assign finish_o    = (load_o && zero_i) || (word_done_o && last_i);

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    unique case (st_q)
      S_IDLE: if (start_i && !zero_i) begin
        st_d = S_BUS;
        ph_d = 1'b0;
      end
      S_BUS: if (beat_o) begin
        if (!word_done_o) ph_d = 1'b1;
        else begin
          ph_d = 1'b0;
          if (last_i)                  st_d = S_IDLE;
          else if (mode_i == MODE_STEAL) st_d = S_GAP;
        end
      end
      S_GAP: st_d = S_BUS;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      ph_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          word_done_i,
  input  logic          finish_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] count_i,
  input  dir_e          dir_i,
  input  mode_e         mode_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          last_o,
  output dir_e          dir_o,
  output mode_e         mode_o,
  output logic          done_o,
  output logic          irq_o
);
  localparam logic [CW-1:0] CntOne = CW'(1);
  localparam logic [AW-1:0] AdrOne = AW'(1);

  logic [CW-1:0] cnt_q;
  assign last_o = (cnt_q == CntOne);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o  <= '0;
      dst_o  <= '0;
      cnt_q  <= '0;
      dir_o  <= DIR_D2M;
      mode_o <= MODE_STEAL;
    end else if (load_i) begin
      src_o  <= src_i;
      dst_o  <= dst_i;
      cnt_q  <= count_i;
      dir_o  <= dir_i;
      mode_o <= mode_i;
    end else if (word_done_i) begin
      cnt_q <= cnt_q - CntOne;
      if (dir_o != DIR_D2M) src_o <= src_o + AdrOne;
      if (dir_o != DIR_M2D) dst_o <= dst_o + AdrOne;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= finish_i;
      if (finish_i)    done_o <= 1'b1;
      else if (load_i) done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_dpath.sv
module dma_dpath
  import dma_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          beat_i,
  input  logic          phase_i,
  input  dir_e          dir_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] dev_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          dev_ack_o,
  output logic [DW-1:0] dev_wdata_o
);
  logic          m2m;
  logic [DW-1:0] hold_q;

  assign m2m         = is_m2m(dir_i);
  assign mem_rd_o    = beat_i && ((dir_i == DIR_M2D) || (m2m && !phase_i));
  assign mem_wr_o    = beat_i && ((dir_i == DIR_D2M) || (m2m && phase_i));
  assign dev_ack_o   = beat_i && !m2m;
  assign mem_addr_o  = mem_wr_o ? dst_i : src_i;
  assign mem_wdata_o = m2m ? hold_q : dev_rdata_i;
  assign dev_wdata_o = mem_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       hold_q <= '0;
    else if (beat_i && m2m && !phase_i) hold_q <= mem_rdata_i;
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_start_i,
  input  logic [AW-1:0] cfg_src_i,
  input  logic [AW-1:0] cfg_dst_i,
  input  logic [CW-1:0] cfg_count_i,
  input  logic [1:0]    cfg_dir_i,
  input  logic          cfg_mode_i,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  input  logic          cpu_idle_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          dev_req_i,
  output logic          dev_ack_o,
  input  logic [DW-1:0] dev_rdata_i,
  output logic [DW-1:0] dev_wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          irq_o
);
  logic          load_w, beat_w, phase_w, word_done_w, finish_w, last_w;
  logic [AW-1:0] src_w, dst_w;
  dir_e          dir_w;
  mode_e         mode_w;

  dma_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (cfg_start_i),
    .zero_i     (cfg_count_i == '0),
    .last_i     (last_w),
    .dir_i      (dir_w),
    .mode_i     (mode_w),
    .gnt_i      (bus_gnt_i),
    .idle_i     (cpu_idle_i),
    .dev_req_i  (dev_req_i),
    .bus_req_o  (bus_req_o),
    .beat_o     (beat_w),
    .phase_o    (phase_w),
    .word_done_o(word_done_w),
    .finish_o   (finish_w),
    .load_o     (load_w),
    .busy_o     (busy_o)
  );

  dma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_w),
    .word_done_i(word_done_w),
    .finish_i   (finish_w),
    .src_i      (cfg_src_i),
    .dst_i      (cfg_dst_i),
    .count_i    (cfg_count_i),
    .dir_i      (dir_e'(cfg_dir_i)),
    .mode_i     (mode_e'(cfg_mode_i)),
    .src_o      (src_w),
    .dst_o      (dst_w),
    .last_o     (last_w),
    .dir_o      (dir_w),
    .mode_o     (mode_w),
    .done_o     (done_o),
    .irq_o      (irq_o)
  );

  dma_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_i     (beat_w),
    .phase_i    (phase_w),
    .dir_i      (dir_w),
    .src_i      (src_w),
    .dst_i      (dst_w),
    .mem_rdata_i(mem_rdata_i),
    .dev_rdata_i(dev_rdata_i),
    .mem_addr_o (mem_addr_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .mem_wdata_o(mem_wdata_o),
    .dev_ack_o  (dev_ack_o),
    .dev_wdata_o(dev_wdata_o)
  );
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk
  import dma_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  bus_req_o,
  input logic  bus_gnt_i,
  input logic  cpu_idle_i,
  input logic  dev_req_i,
  input logic  dev_ack_o,
  input logic  mem_rd_o,
  input logic  mem_wr_o,
  input logic  busy_o,
  input logic  done_o,
  input logic  irq_o,
  input mode_e mode_w,
  input logic  word_done_w,
  input logic  finish_w
);
  a_r3_strobe_needs_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o || dev_ack_o) |-> (bus_req_o && bus_gnt_i));

  a_r3_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  a_r5_steal_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w == MODE_STEAL && word_done_w && !finish_w) |=> !bus_req_o);

  a_r6_transp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w == MODE_TRANSP && (mem_rd_o || mem_wr_o)) |-> cpu_idle_i);

  a_r6_transp_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w == MODE_TRANSP && word_done_w && !finish_w) |=> bus_req_o);

  a_r7_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_ack_o |-> dev_req_i);

  a_r8_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r8_irq_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (done_o && !busy_o));

  a_r8_finish_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_w |=> (!bus_req_o && irq_o));
endmodule

bind dma_engine dma_engine_chk u_chk (.*);

// File: tb/sim_dma_engine.sv
module sim_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] src = '0, dst = '0;
  logic [15:0] cnt = '0;
  logic [1:0]  dir = '0;
  logic        mode = 1'b0;
  logic        gnt = 1'b0, idle = 1'b0, dreq = 1'b0;
  logic [15:0] drd = '0;
  logic        req, mrd, mwr, ack, busy, done, irq;
  logic [23:0] addr;
  logic [15:0] mwd, mrdata, dwd;

  int n_cmp = 0, n_bad = 0, n_ack = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] memfn(input logic [23:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8]};
  endfunction
  assign mrdata = memfn(addr);

  dma_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_start_i(start), .cfg_src_i(src), .cfg_dst_i(dst),
    .cfg_count_i(cnt), .cfg_dir_i(dir), .cfg_mode_i(mode), .bus_req_o(req), .bus_gnt_i(gnt),
    .cpu_idle_i(idle), .mem_addr_o(addr), .mem_rd_o(mrd), .mem_wr_o(mwr), .mem_wdata_o(mwd),
    .mem_rdata_i(mrdata), .dev_req_i(dreq), .dev_ack_o(ack), .dev_rdata_i(drd),
    .dev_wdata_o(dwd), .busy_o(busy), .done_o(done), .irq_o(irq));

  // reference model
  bit          m_busy, m_bus, m_gap, m_phase, m_done, m_irq, m_mode;
  logic [1:0]  m_dir;
  logic [23:0] m_src, m_dst;
  logic [15:0] m_hold;
  int          m_cnt;

  function automatic bit beat_now();
    return m_bus && gnt && (!m_mode || idle) && (m_dir[1] || dreq);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_bus = 0; m_gap = 0; m_phase = 0; m_done = 0; m_irq = 0;
      m_mode = 0; m_dir = 0; m_src = 0; m_dst = 0; m_hold = 0; m_cnt = 0;
    end else begin
      bit b, fin;
      b = beat_now();
      fin = 0;
      if (!m_busy) begin
        if (start) begin
          if (cnt == 0) fin = 1;
          else begin
            m_src = src; m_dst = dst; m_cnt = cnt; m_dir = dir; m_mode = mode;
            m_busy = 1; m_bus = 1; m_phase = 0; m_done = 0;
          end
        end
      end else if (m_gap) begin
        m_gap = 0; m_bus = 1;
      end else if (b) begin
        if (m_dir[1] && !m_phase) begin
          m_hold = memfn(m_src); m_phase = 1;
        end else begin
          m_phase = 0;
          if (m_dir != 2'b00) m_src = m_src + 24'd1;
          if (m_dir != 2'b01) m_dst = m_dst + 24'd1;
          m_cnt--;
          if (m_cnt == 0) begin m_busy = 0; m_bus = 0; fin = 1; end
          else if (!m_mode) begin m_bus = 0; m_gap = 1; end
        end
      end
      if (fin) m_done = 1;
      m_irq = fin;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // stimulus and per-cycle compare
  always @(negedge clk) begin
    if (rst_n) begin
      bit b, e_rd, e_wr, e_ack;
      gnt  = req && ($urandom_range(0, 3) != 0);
      idle = ($urandom_range(0, 2) != 0);
      dreq = ($urandom_range(0, 3) != 0);
      drd  = 16'($urandom);
      #1;
      b     = beat_now();
      e_rd  = b && (m_dir == 2'b01 || (m_dir[1] && !m_phase));
      e_wr  = b && (m_dir == 2'b00 || (m_dir[1] && m_phase));
      e_ack = b && !m_dir[1];
      chk(req == m_bus, "R5/R6 bus_req", 32'(req), 32'(m_bus));
      chk(mrd == e_rd && mwr == e_wr, "R3 strobes", {30'd0, mrd, mwr}, {30'd0, e_rd, e_wr});
      chk(ack == e_ack, "R7 dev_ack", 32'(ack), 32'(e_ack));
      chk(busy == m_busy, "R1 busy", 32'(busy), 32'(m_busy));
      chk(done == m_done, "R8 done", 32'(done), 32'(m_done));
      chk(irq == m_irq, "R8 irq", 32'(irq), 32'(m_irq));
      if (e_wr) begin
        chk(addr == m_dst, "R11 write addr", 32'(addr), 32'(m_dst));
        chk(mwd == (m_dir[1] ? m_hold : drd), "R4/R7 wdata", 32'(mwd),
            32'(m_dir[1] ? m_hold : drd));
      end
      if (e_rd) chk(addr == m_src, "R4 read addr", 32'(addr), 32'(m_src));
      if (e_ack && m_dir == 2'b01) chk(dwd == memfn(m_src), "R7 dev_wdata", 32'(dwd), 32'(memfn(m_src)));
      if (ack) n_ack++;
    end
  end

  task automatic kick(input logic [23:0] s, input logic [23:0] d, input int c,
                      input logic [1:0] dr, input bit md);
    @(negedge clk);
    src = s; dst = d; cnt = 16'(c); dir = dr; mode = md; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_end();
    int guard = 0;
    while (m_busy && guard < 5000) begin @(posedge clk); guard++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] s, input logic [23:0] d, input int c,
                      input logic [1:0] dr, input bit md, input string tag);
    int a0;
    a0 = n_ack;
    kick(s, d, c, dr, md);
    wait_end();
    chk(done == 1'b1, {tag, " done after run"}, 32'(done), 32'd1);
    if (!dr[1]) chk(n_ack - a0 == c, {tag, " word count"}, 32'(n_ack - a0), 32'(c));
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
          n_cmp++; n_bad++;
          $display("FAIL watchdog expired act=hung exp=finished");
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
          $finish;
        end
      end
    join_none
    repeat (3) @(negedge clk);
    #1;
    chk(req == 0 && busy == 0 && done == 0 && irq == 0, "R1 reset state",
        {28'd0, req, busy, done, irq}, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    xfer(24'h000100, 24'h002000, 5, 2'b00, 1'b0, "R2 d2m steal");
    xfer(24'h000300, 24'h004000, 6, 2'b01, 1'b1, "R2 m2d transp");
    xfer(24'h001000, 24'h005000, 4, 2'b10, 1'b0, "R4 m2m steal");
    xfer(24'h001100, 24'h005100, 4, 2'b11, 1'b1, "R4 m2m transp");
    xfer(24'hFFFFFE, 24'hFFFFFD, 5, 2'b10, 1'b0, "R11 wrap");
    // R12: done cleared by new start
    kick(24'h0, 24'h000010, 3, 2'b00, 1'b1);
    #1;
    chk(done == 1'b0, "R12 done cleared", 32'(done), 32'd0);
    wait_end();
    // R10: zero count
    begin
      bit saw_req = 0;
      kick(24'h0, 24'h0, 0, 2'b10, 1'b0);
      #1;
      chk(irq == 1'b1 && done == 1'b1, "R10 zero count irq", {30'd0, irq, done}, 32'd3);
      repeat (4) begin @(negedge clk); #1; if (req) saw_req = 1; end
      chk(!saw_req, "R10 no bus request", 32'(saw_req), 32'd0);
    end
    // R9: start while busy ignored
    begin
      int a0;
      a0 = n_ack;
      kick(24'h000400, 24'h006000, 8, 2'b00, 1'b0);
      repeat (3) @(negedge clk);
      kick(24'h000900, 24'h009000, 2, 2'b01, 1'b1);
      wait_end();
      chk(n_ack - a0 == 8, "R9 start ignored word count", 32'(n_ack - a0), 32'd8);
    end
    for (int i = 0; i < 6; i++)
      xfer(24'(i * 37), 24'(24'h8000 + i * 53), 1 + i, 2'(i % 4), 1'(i % 2), "R1 mixed");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule